// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block takes one asynchronous serial line and rebuilds each frame into a
parallel word. A frame is a low start bit, then 5 to 8 data bits sent least
significant bit first, then an optional parity bit and one or more high stop
bits. Bit timing comes from a one-cycle enable pulse, `tick16`, that a
separate divider raises sixteen times per bit period. A falling edge on the
idle line starts a frame. The line is checked again half a bit later to reject
glitches. After that, each bit is sampled once at its middle.

The receiver has two buffers. A shift register assembles the incoming frame
while the previous word waits in a holding register until the host
acknowledges it. Each word carries its own parity, framing and break flags,
and an overrun flag shows that an unread word was overwritten. A loopback
select makes the receiver listen to a local serial source instead of the
external line. Word length and parity mode are static configuration inputs.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `dataReady`, `overrun`, `parityErr`, `frameErr` and `breakDet` are 0 and `rxData` is 0.
- R2: `wordLen` selects the number of data bits: 2'b00 = 5, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8. The first data bit received lands in `rxData[0]`, and bits above the word length read as 0.
- R3: A low pulse on the idle line that has ended by the half-bit check after its falling edge produces no word.
- R4: With `parEn` = 1, one parity bit follows the data. `parOdd` = 0 selects even parity and `parOdd` = 1 selects odd parity. A mismatch sets `parityErr` together with that word. With `parEn` = 0 there is no parity bit and `parityErr` stays 0.
- R5: A low line at the first stop bit sample sets `frameErr` with that word. The receiver then waits for the line to go high before it hunts for a new start bit.
- R6: If the line stays low through the start, data, parity and first stop bit, the all-zero word is loaded with `breakDet` and `frameErr` set. No further word is produced while the line stays low.
- R7: A completed frame loads the holding register and sets `dataReady`. A cycle with `rdAck` high and no load clears `dataReady` and all error flags. `rxData` changes only when a frame completes.
- R8: If a frame completes while `dataReady` is still set and `rdAck` is not asserted in that cycle, `overrun` is set and `rxData` takes the new word.
- R9: With `loopEn` = 1 the receiver decodes `loopIn` and ignores `lineIn`. With `loopEn` = 0 it decodes `lineIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| lineIn | input | 1 | External serial line, idle high |
| loopIn | input | 1 | Local serial source used in loopback |
| loopEn | input | 1 | 1 selects `loopIn` as the receive source |
| wordLen | input | 2 | Data bits per frame, minus 5 |
| parEn | input | 1 | Parity bit present and checked |
| parOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rdAck | input | 1 | Host has read the word; clears ready and flags |
| rxData | output | 8 | Holding register, right-justified word |
| dataReady | output | 1 | An unread word is in the holding register |
| overrun | output | 1 | An unread word was overwritten |
| parityErr | output | 1 | Parity mismatch on the held word |
| frameErr | output | 1 | Stop bit sampled low on the held word |
| breakDet | output | 1 | Held word came from a line held low for a whole frame |

## Verification
The bench uses the default parameters: `OVERSAMPLE` = 16 and `SYNC_STAGES` = 2. It raises `tick16` on every fourth clock, so one bit lasts 64 clocks. At that rate a single run can cover all four word lengths, both parity senses and the unchecked mode. It also leaves room for a three-tick glitch, a break held for fourteen bit times, two back-to-back unread frames for overrun, and a loopback frame sent while the external line is held low.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int MAX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_HOLDOFF
  } rxState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic frameBegin;
    logic dataSample;
    logic paritySample;
    logic stopSample;
  } rxStrobe_t;

endpackage

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      rxBit,
  input  logic [1:0] wordLen,
  input  logic      parEn,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2 - 1;
  localparam int LAST  = OVERSAMPLE - 1;

  rxState_t   state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [2:0] bitCnt, bitNext;
  logic       lastBit;
  logic       bitDone;

  // index of the final data bit is 4 + wordLen
  assign lastBit = (bitCnt == {1'b1, wordLen});
  assign bitDone = (cnt == CNT_W'(LAST));

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    bitNext   = bitCnt;
    stb       = '0;
    if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!rxBit) begin
            stateNext      = ST_START;
            cntNext        = '0;
            stb.frameBegin = 1'b1;
          end
        end
        ST_START: begin
          if (cnt == CNT_W'(MID)) begin
            cntNext   = '0;
            bitNext   = '0;
            stateNext = rxBit ? ST_IDLE : ST_DATA;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bitDone) begin
            cntNext        = '0;
            stb.dataSample = 1'b1;
            if (lastBit) stateNext = parEn ? ST_PARITY : ST_STOP;
            else         bitNext   = bitCnt + 1'b1;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (bitDone) begin
            cntNext          = '0;
            stb.paritySample = 1'b1;
            stateNext        = ST_STOP;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bitDone) begin
            cntNext        = '0;
            stb.stopSample = 1'b1;
            stateNext      = rxBit ? ST_IDLE : ST_HOLDOFF;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_HOLDOFF: begin
          if (rxBit) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      bitCnt <= bitNext;
    end
  end

endmodule

// File: rtl/srx_datapath.sv
module srx_datapath
  import srx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineIn,
  input  logic                loopIn,
  input  logic                loopEn,
  input  rxStrobe_t           stb,
  input  logic [1:0]          wordLen,
  input  logic                parEn,
  input  logic                parOdd,
  input  logic                rdAck,
  output logic                rxBit,
  output logic [MAX_BITS-1:0] rxData,
  output logic                dataReady,
  output logic                overrun,
  output logic                parityErr,
  output logic                frameErr,
  output logic                breakDet
);

  logic [SYNC_STAGES:0] syncChain;
  logic [MAX_BITS-1:0]  shReg;
  logic [MAX_BITS-1:0]  wordOut;
  logic [1:0]           shAmt;
  logic                 parAcc;
  logic                 allLow;
  logic                 parBad;

  assign syncChain[0] = loopEn ? loopIn : lineIn;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g+1] <= 1'b1;
        else       syncChain[g+1] <= syncChain[g];
      end
    end
  endgenerate

  assign rxBit = syncChain[SYNC_STAGES];

  // bits enter at the top, so a short word sits high and is right-aligned here
  assign shAmt   = 2'd3 - wordLen;
  assign wordOut = shReg >> shAmt;
  assign parBad  = parEn & (parAcc ^ parOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parAcc <= 1'b0;
      allLow <= 1'b1;
    end else begin
      if (stb.frameBegin) begin
        parAcc <= 1'b0;
        allLow <= 1'b1;
      end
      if (stb.dataSample) begin
        shReg  <= {rxBit, shReg[MAX_BITS-1:1]};
        parAcc <= parAcc ^ rxBit;
        if (rxBit) allLow <= 1'b0;
      end
      if (stb.paritySample) begin
        parAcc <= parAcc ^ rxBit;
        if (rxBit) allLow <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      dataReady <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
    end else if (stb.stopSample) begin
      rxData    <= wordOut;
      dataReady <= 1'b1;
      overrun   <= dataReady & ~rdAck;
      parityErr <= parBad;
      frameErr  <= ~rxBit;
      breakDet  <= allLow & ~rxBit;
    end else if (rdAck) begin
      dataReady <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      breakDet  <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       lineIn,
  input  logic       loopIn,
  input  logic       loopEn,
  input  logic [1:0] wordLen,
  input  logic       parEn,
  input  logic       parOdd,
  input  logic       rdAck,
  output logic [7:0] rxData,
  output logic       dataReady,
  output logic       overrun,
  output logic       parityErr,
  output logic       frameErr,
  output logic       breakDet
);

  rxStrobe_t stb;
  logic      rxBit;

  srx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick16),
    .rxBit   (rxBit),
    .wordLen (wordLen),
    .parEn   (parEn),
    .stb     (stb)
  );

  srx_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .loopIn    (loopIn),
    .loopEn    (loopEn),
    .stb       (stb),
    .wordLen   (wordLen),
    .parEn     (parEn),
    .parOdd    (parOdd),
    .rdAck     (rdAck),
    .rxBit     (rxBit),
    .rxData    (rxData),
    .dataReady (dataReady),
    .overrun   (overrun),
    .parityErr (parityErr),
    .frameErr  (frameErr),
    .breakDet  (breakDet)
  );

endmodule

// File: rtl/serial_frame_rx_chk.sv
module serial_frame_rx_chk
  import srx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rdAck,
  input logic       parEn,
  input rxStrobe_t  stb,
  input logic [7:0] rxData,
  input logic       dataReady,
  input logic       overrun,
  input logic       parityErr,
  input logic       frameErr,
  input logic       breakDet
);

  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopSample |=> dataReady); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdAck && !stb.stopSample |=> !dataReady && !overrun); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.stopSample |=> $stable(rxData)); // R7

  AST_OVERRUN_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopSample && dataReady && !rdAck |=> overrun); // R8

  AST_NO_PARITY_ERR_OFF: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopSample && !parEn |=> !parityErr); // R4

  AST_BREAK_ZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> frameErr && (rxData == 8'h00)); // R6

endmodule

bind serial_frame_rx serial_frame_rx_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdAck     (rdAck),
  .parEn     (parEn),
  .stb       (stb),
  .rxData    (rxData),
  .dataReady (dataReady),
  .overrun   (overrun),
  .parityErr (parityErr),
  .frameErr  (frameErr),
  .breakDet  (breakDet)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;

  localparam int BIT_CLK = 64;

  typedef struct {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    string      req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16;
  logic [1:0] tickCnt;
  logic       drv = 1'b1;
  logic       useLoop = 1'b0;
  logic       lineIn, loopIn, loopEn;
  logic [1:0] wordLen = 2'b11;
  logic       parEn = 1'b0, parOdd = 1'b0;
  logic       monAck = 1'b0, manAck = 1'b0, autoAck = 1'b0;
  logic       rdAck;
  logic [7:0] rxData;
  logic       dataReady, overrun, parityErr, frameErr, breakDet;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tickCnt <= '0;
    else       tickCnt <= tickCnt + 1'b1;
  end
  assign tick16 = (tickCnt == 2'd3);

  assign lineIn = useLoop ? 1'b0 : drv;
  assign loopIn = useLoop ? drv : 1'b1;
  assign loopEn = useLoop;
  assign rdAck  = monAck | manAck;

  serial_frame_rx u0 (
    .clk(clk), .rstN(rstN), .tick16(tick16), .lineIn(lineIn), .loopIn(loopIn),
    .loopEn(loopEn), .wordLen(wordLen), .parEn(parEn), .parOdd(parOdd),
    .rdAck(rdAck), .rxData(rxData), .dataReady(dataReady), .overrun(overrun),
    .parityErr(parityErr), .frameErr(frameErr), .breakDet(breakDet)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    drv = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic [1:0] wl,
                           input logic pe, input logic po, input logic badPar,
                           input logic badStop, input bit push, input string req);
    logic [7:0] m;
    logic       pbit;
    expItem_t   it;
    @(negedge clk);
    wordLen = wl; parEn = pe; parOdd = po;
    m = d & (8'hFF >> (2'd3 - wl));
    pbit = (^m) ^ po ^ badPar;
    if (push) begin
      it.data = m; it.pe = pe & badPar; it.fe = badStop; it.req = req;
      expQ.push_back(it);
    end
    sendBit(1'b0);
    for (int i = 0; i < 5 + int'(wl); i++) sendBit(m[i]);
    if (pe) sendBit(pbit);
    sendBit(~badStop);
    sendBit(1'b1);
  endtask

  task automatic pulseAck();
    @(negedge clk); manAck = 1'b1;
    @(negedge clk); manAck = 1'b0;
  endtask

  // monitor: pops expected items as words appear and acknowledges them
  initial begin
    forever begin
      @(negedge clk);
      if (autoAck && dataReady && !monAck) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected word", {24'h0, rxData}, 32'h0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(rxData == it.data, it.req, {24'h0, rxData}, {24'h0, it.data});
          chk(parityErr == it.pe, "R4 parityErr", {31'h0, parityErr}, {31'h0, it.pe});
          chk(frameErr == it.fe, "R5 frameErr", {31'h0, frameErr}, {31'h0, it.fe});
          chk(breakDet == 1'b0, "R6 no break", {31'h0, breakDet}, 32'h0);
        end
        monAck = 1'b1;
      end else begin
        monAck = 1'b0;
      end
    end
  end

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dataReady == 0, "R1 dataReady", {31'h0, dataReady}, 0);
    chk(overrun == 0 && parityErr == 0, "R1 overrun/parity", {30'h0, overrun, parityErr}, 0);
    chk(frameErr == 0 && breakDet == 0, "R1 frame/break", {30'h0, frameErr, breakDet}, 0);
    chk(rxData == 0, "R1 rxData", {24'h0, rxData}, 0);

    autoAck = 1'b1;
    sendBit(1'b1);
    // R2 word lengths, R4 parity modes
    sendFrame(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R2 8-bit word");
    sendFrame(8'hF3, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1, "R2 5-bit word");
    sendFrame(8'h2C, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1, "R2 6-bit word");
    sendFrame(8'hD5, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1, "R2 7-bit word");
    sendFrame(8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1, "R4 odd parity zero");
    sendFrame(8'h3C, 2'b11, 1'b1, 1'b0, 1'b1, 1'b0, 1, "R4 bad even parity");
    sendFrame(8'h5A, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1, "R4 bad odd parity");
    sendFrame(8'h41, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1, "R5 bad stop");
    sendFrame(8'h81, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R5 after framing error");

    // R3 glitch of three ticks
    @(negedge clk); drv = 1'b0;
    repeat (12) @(negedge clk);
    drv = 1'b1;
    repeat (3 * BIT_CLK) @(negedge clk);
    chk(dataReady == 0, "R3 glitch ignored", {31'h0, dataReady}, 0);

    // R8 overrun
    autoAck = 1'b0;
    sendFrame(8'h11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R8");
    sendFrame(8'h22, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R8");
    chk(dataReady == 1, "R8 dataReady", {31'h0, dataReady}, 1);
    chk(overrun == 1, "R8 overrun set", {31'h0, overrun}, 1);
    chk(rxData == 8'h22, "R8 overwritten", {24'h0, rxData}, 32'h22);
    pulseAck();
    @(negedge clk);
    chk(overrun == 0 && dataReady == 0, "R7 ack clears", {30'h0, overrun, dataReady}, 0);

    // R6 break: line low for fourteen bit times
    @(negedge clk); wordLen = 2'b11; parEn = 1'b1; parOdd = 1'b0;
    sendBit(1'b0);
    repeat (13) sendBit(1'b0);
    chk(dataReady == 1, "R6 break word ready", {31'h0, dataReady}, 1);
    chk(rxData == 8'h00, "R6 break word zero", {24'h0, rxData}, 0);
    chk(breakDet == 1, "R6 breakDet", {31'h0, breakDet}, 1);
    chk(frameErr == 1, "R6 frameErr", {31'h0, frameErr}, 1);
    pulseAck();
    repeat (3) sendBit(1'b0);
    chk(dataReady == 0, "R6 no word while low", {31'h0, dataReady}, 0);
    sendBit(1'b1);
    autoAck = 1'b1;
    sendFrame(8'h6E, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1, "R6 word after break");

    // R9 loopback while the external line is held low
    @(negedge clk); useLoop = 1'b1; drv = 1'b1;
    sendBit(1'b1);
    sendFrame(8'hC3, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R9 loopback word");
    sendBit(1'b1);
    @(negedge clk); useLoop = 1'b0;
    sendBit(1'b1);

    repeat (4 * BIT_CLK) @(negedge clk);
    chk(expQ.size() == 0, "R7 all words delivered", expQ.size(), 0);
    chk(dataReady == 0, "R9 external low ignored", {31'h0, dataReady}, 0);
    finishRun();
  end

endmodule